// File: doc/BRIEF.md
# Shadowed Configuration Commit Controller

This block holds the configuration registers of a display engine in two copies. Software writes and reads a shadow copy through a simple address/data port. The pixel pipeline sees only the active copy, and the active copy changes only on a frame boundary, which the `vblank` pulse marks. Software asks for an update through a self-clearing load bit in a control word. That bit stays set until the vblank that moves the whole shadow bank into the active bank. Software polls it and does not prepare the next frame's values until it reads back clear.

A second control bit turns off automatic copying. With that bit clear, the bank is copied at every vblank. A third bit marks a pending teardown of a layer fed by an upstream source unit. That unit must stay enabled until the frame that drops the layer actually takes effect. The block gives a one-cycle disable strobe right after the vblank on which a requested commit completes, then clears the mark. Reset clears both banks and the control word to zero, so the layer settings never start from undefined values.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: Synchronous reset clears every shadow and active word, the control word, `rd_data`, `commit_pending` and `src_disable` to zero.
- R2: A shadow write does not change `active_cfg` until a vblank copies it. On any cycle without `vblank`, `active_cfg` is held.
- R3: While the load bit is set, the next `vblank` copies every shadow word into the active bank, visible the cycle after the vblank. The load bit is clear from that same cycle.
- R4: The control word sits at address 0, with bit 0 as the load request, bit 1 as autoload-disable and bit 2 as teardown-pending. Writing 1 to bit 0 sets the load bit and writing 0 does not clear it. `commit_pending` shows the live load bit.
- R5: With autoload-disable set and no load request, a vblank leaves the active bank unchanged.
- R6: With autoload-disable clear, every vblank copies the shadow bank, whether or not a load is requested.
- R7: A control write that sets the load bit in the same cycle as `vblank` is committed at that vblank. The control fields written in that cycle govern the copy.
- R8: Shadow writes are accepted while a commit is pending. A shadow write in the same cycle as a copying vblank is the value transferred.
- R9: Writing 1 to bit 2 sets teardown-pending, and writing 0 does not clear it. `src_disable` pulses for exactly one cycle, the cycle after the first vblank that completes a load request, and the flag is then clear. Autoload copies without a load request give no pulse.
- R10: `rd_data` is registered one cycle after `rd_addr`. Address 0 returns the control word in bits 2:0. Address k, for 1 ≤ k ≤ NREG, returns shadow word k-1. Any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W | Write address: 0 is control, 1..NREG are shadow words |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| vblank | input | 1 | Single-cycle frame boundary pulse |
| active_cfg | output | NREG*DATA_W | Active bank, word k at bits k*DATA_W upward |
| commit_pending | output | 1 | Live load bit |
| src_disable | output | 1 | One-cycle deferred disable strobe for the upstream source |

## Verification
The bench drives a write to the control word in the same cycle as vblank. A design that samples only the stored load bit would miss that frame. It writes a shadow word in the same cycle as a committing vblank, where a design that copies the stored shadow would send the previous value to the pipeline. It sets teardown while autoload is active, and a strobe tied to any copy rather than to a completed load request would release the upstream unit a frame early. It also writes 0 to the load and teardown bits while they are pending, which catches designs that let software cancel them.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int CTL_LOAD   = 0;
  localparam int CTL_NOAUTO = 1;
  localparam int CTL_TEAR   = 2;
  localparam int CTL_W      = 3;

  typedef struct packed {
    logic tear;
    logic noauto;
    logic load;
  } ctl_t;
endpackage

// File: rtl/shc_ctrl.sv
module shc_ctrl
  import shc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             vblank,
  output logic             copy_en,
  output ctl_t             ctl_q,
  output logic             src_disable
);
  logic load_eff, noauto_eff, tear_eff, commit;

  always_comb begin
    load_eff   = ctl_q.load | (ctl_we & ctl_wdata[CTL_LOAD]);
    noauto_eff = ctl_we ? ctl_wdata[CTL_NOAUTO] : ctl_q.noauto;
    tear_eff   = ctl_q.tear | (ctl_we & ctl_wdata[CTL_TEAR]);
    commit     = vblank & load_eff;
    copy_en    = vblank & (load_eff | ~noauto_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= '0;
      src_disable <= 1'b0;
    end else begin
      ctl_q.load   <= load_eff & ~commit;
      ctl_q.noauto <= noauto_eff;
      ctl_q.tear   <= tear_eff & ~commit;
      src_disable  <= tear_eff & commit;
    end
  end
endmodule

// File: rtl/shc_bank.sv
module shc_bank #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          copy_en,
  output logic [NREG-1:0][DATA_W-1:0]   shadow_q,
  output logic [NREG-1:0][DATA_W-1:0]   active_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DATA_W-1:0] shadow_d;
    always_comb
      shadow_d = (wr_en && wr_idx == IDX_W'(g)) ? wr_data : shadow_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        shadow_q[g] <= shadow_d;
        if (copy_en) active_q[g] <= shadow_d;
      end
    end
  end
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
  import shc_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(NREG + 1),
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   vblank,
  output logic [NREG*DATA_W-1:0] active_cfg,
  output logic                   commit_pending,
  output logic                   src_disable
);
  logic                        ctl_we, bank_we, copy_en;
  logic [IDX_W-1:0]            wr_idx, rd_idx;
  ctl_t                        ctl_q;
  logic [NREG-1:0][DATA_W-1:0] shadow_q, active_q;

  always_comb begin
    ctl_we  = wr_en && (wr_addr == '0);
    bank_we = wr_en && (wr_addr != '0) && (wr_addr <= ADDR_W'(NREG));
    wr_idx  = IDX_W'(wr_addr - ADDR_W'(1));
    rd_idx  = IDX_W'(rd_addr - ADDR_W'(1));
  end

  shc_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .ctl_wdata   (wr_data[CTL_W-1:0]),
    .vblank      (vblank),
    .copy_en     (copy_en),
    .ctl_q       (ctl_q),
    .src_disable (src_disable)
  );

  shc_bank #(.NREG(NREG), .DATA_W(DATA_W)) i_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bank_we),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .copy_en  (copy_en),
    .shadow_q (shadow_q),
    .active_q (active_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr == '0)
      rd_data <= DATA_W'(ctl_q);
    else if (rd_addr <= ADDR_W'(NREG))
      rd_data <= shadow_q[rd_idx];
    else
      rd_data <= '0;
  end

  assign active_cfg     = active_q;
  assign commit_pending = ctl_q.load;
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst,
  input logic         vblank,
  input logic         commit_pending,
  input logic         src_disable,
  input logic [W-1:0] active_cfg
);
  p_active_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !vblank |=> $stable(active_cfg));

  p_load_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (commit_pending && vblank) |=> !commit_pending);

  p_pending_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_pending && !vblank) |=> commit_pending);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    src_disable |=> !src_disable);

  p_strobe_after_vblank_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(src_disable) |-> $past(vblank));
endmodule

bind shadow_commit_ctrl shc_checker #(.W(NREG*DATA_W)) i_shc_checker (
  .clk            (clk),
  .rst            (rst),
  .vblank         (vblank),
  .commit_pending (commit_pending),
  .src_disable    (src_disable),
  .active_cfg     (active_cfg)
);

// File: tb/test_shadow_commit_ctrl.sv
module test_shadow_commit_ctrl;
  localparam int  NREG   = 8;
  localparam int  DATA_W = 16;
  localparam int  ADDR_W = $clog2(NREG + 1);
  localparam time CLK_PERIOD = 10ns;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   wr_en = 1'b0;
  logic [ADDR_W-1:0]      wr_addr = '0;
  logic [DATA_W-1:0]      wr_data = '0;
  logic [ADDR_W-1:0]      rd_addr = '0;
  logic [DATA_W-1:0]      rd_data;
  logic                   vblank = 1'b0;
  logic [NREG*DATA_W-1:0] active_cfg;
  logic                   commit_pending;
  logic                   src_disable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  shadow_commit_ctrl #(.NREG(NREG), .DATA_W(DATA_W)) i_shadow_commit_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vblank(vblank),
    .active_cfg(active_cfg), .commit_pending(commit_pending),
    .src_disable(src_disable)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference state
  int m_sh [NREG];
  int m_act[NREG];
  bit m_load, m_noauto, m_tear, m_dis;
  int m_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
      m_load = 0; m_noauto = 0; m_tear = 0; m_dis = 0; m_rd = 0;
    end else begin
      bit cw, ld, na, td, commit, copy;
      int a;
      a = int'(rd_addr);
      if (a == 0) m_rd = {m_tear, m_noauto, m_load};
      else if (a <= NREG) m_rd = m_sh[a-1];
      else m_rd = 0;
      cw = wr_en && wr_addr == 0;
      ld = m_load || (cw && wr_data[0]);
      na = cw ? wr_data[1] : m_noauto;
      td = m_tear || (cw && wr_data[2]);
      if (wr_en && wr_addr >= 1 && int'(wr_addr) <= NREG)
        m_sh[int'(wr_addr)-1] = int'(wr_data);
      commit = vblank && ld;
      copy   = vblank && (ld || !na);
      if (copy) foreach (m_act[i]) m_act[i] = m_sh[i];
      m_dis    = td && commit;
      m_load   = ld && !commit;
      m_noauto = na;
      m_tear   = td && !commit;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int word(input int k);
    return int'(active_cfg[k*DATA_W +: DATA_W]);
  endfunction

  // compare against the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      foreach (m_act[i]) check(word(i), m_act[i], "R2 active word");
      check(int'(commit_pending), int'(m_load), "R4 pending");
      check(int'(src_disable), int'(m_dis), "R9 strobe");
      check(int'(rd_data), m_rd, "R10 readback");
    end
  end

  task automatic cyc(input bit we, input int addr, input int data, input bit vb, input int ra = 0);
    @(negedge clk);
    wr_en = we; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
    vblank = vb; rd_addr = ADDR_W'(ra);
    @(negedge clk);
    wr_en = 0; vblank = 0;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(active_cfg == '0), 1, "R1 active zero");
    check(int'(commit_pending), 0, "R1 pending zero");
    check(int'(src_disable), 0, "R1 strobe zero");
    check(int'(rd_data), 0, "R1 readback zero");
    rst = 0;

    // R5: autoload off, shadow written, vblank does not copy
    cyc(1, 0, 'h2, 0);
    for (int k = 1; k <= NREG; k++) cyc(1, k, 'h100 + k, 0);
    cyc(0, 0, 0, 1);
    check(word(0), 0, "R5 no copy without load");
    check(word(NREG-1), 0, "R5 no copy without load");

    // R4: load request, writing 0 does not cancel it
    cyc(1, 0, 'h3, 0);
    check(int'(commit_pending), 1, "R4 load set");
    cyc(1, 0, 'h2, 0, 0);
    check(int'(commit_pending), 1, "R4 write zero keeps load");
    check(int'(rd_data), 'h3, "R10 control readback");
    // R8: shadow write while pending is accepted
    cyc(1, 1, 'hAAAA, 0);
    // R3/R8: commit vblank with same-cycle shadow write
    cyc(1, 2, 'hBBBB, 1);
    check(word(0), 'hAAAA, "R8 pending write transferred");
    check(word(1), 'hBBBB, "R8 same-cycle write transferred");
    check(word(2), 'h103, "R3 bank copied");
    check(int'(commit_pending), 0, "R3 load cleared");

    // R7: control write with load in the vblank cycle
    cyc(1, 3, 'h1234, 0);
    cyc(1, 0, 'h3, 1);
    check(word(2), 'h1234, "R7 same-cycle commit");
    check(int'(commit_pending), 0, "R7 load cleared");

    // R6: autoload on, every vblank copies
    cyc(1, 0, 'h0, 0);
    cyc(1, 4, 'h4444, 0);
    cyc(0, 0, 0, 1);
    check(word(3), 'h4444, "R6 autoload copy");
    cyc(1, 4, 'h5555, 0);
    cyc(0, 0, 0, 1);
    check(word(3), 'h5555, "R6 autoload second copy");

    // R9: autoload copy gives no strobe; completed load does
    cyc(1, 0, 'h4, 0);
    @(negedge clk); vblank = 1;
    @(posedge clk); #1;
    check(int'(src_disable), 0, "R9 no strobe on autoload copy");
    @(negedge clk); vblank = 0;
    cyc(1, 0, 'h1, 0, 0);
    check(int'(rd_data), 'h4, "R9 teardown kept by zero write");
    @(negedge clk); vblank = 1;
    @(posedge clk); #1;
    check(int'(src_disable), 1, "R9 strobe after commit");
    @(negedge clk); vblank = 0;
    @(posedge clk); #1;
    check(int'(src_disable), 0, "R9 strobe single cycle");
    cyc(0, 0, 0, 0, 0);
    check(int'(rd_data), 'h0, "R9 teardown cleared");

    // R10: out-of-range read
    cyc(0, 0, 0, 0, NREG + 3);
    check(int'(rd_data), 0, "R10 out of range");
    cyc(0, 0, 0, 0, 5);
    check(int'(rd_data), 'h105, "R10 shadow readback");

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 2) != 0);
      wr_addr = ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1));
      wr_data = DATA_W'($urandom);
      rd_addr = ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1));
      vblank  = !vblank && ($urandom_range(0, 6) == 0);
    end
    @(negedge clk);
    wr_en = 0; vblank = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule